// File: doc/BRIEF.md
# Reset-Gated Memory Access Guard

This block sits between the serial command front end of a non-volatile memory and its internal write engine. It watches a system reset level and keeps the memory from acting on traffic while that reset is asserted. If a bus transaction is under way when reset rises, the guard aborts it at once. No new transaction is admitted while reset is high, and no internal write cycle may be launched in that time.

The write engine is handled differently from the bus. A write cycle that has already been launched keeps running to its end even if reset arrives part way through, because stopping it would leave the stored cell half programmed. The write duration is a parameter in clock cycles; the default is 5 ms at 100 MHz.

After reset is released, the bus does not resume on its own. The command decoder has to issue a fresh transaction-start strobe before the guard enables the transaction path again. The chip-level asynchronous reset `rst_n` is resynchronised inside the block before it clears the state. The monitored level `sys_rst` is expected to be synchronous to `clk` already.

Top module: `mem_rst_guard`

## Requirements
- R1: Once `rst_n` has been released, and with all other inputs low, the outputs `xfer_abort`, `xfer_en`, `wr_start` and `wr_busy` are all 0.
- R2: When `xfer_start` is high and `sys_rst` is low, `xfer_en` is 1 after the next clock edge. It stays 1 while `xfer_active` is high and returns to 0 on the edge after a cycle in which both `xfer_active` and `xfer_start` are low.
- R3: Any cycle with `sys_rst` high makes `xfer_en` 0 after the next edge, and `xfer_start` is refused in such a cycle.
- R4: When `wr_req` is high in a cycle where `sys_rst` and `wr_busy` are both low, `wr_start` is 1 for exactly one cycle after the next edge, and `wr_busy` rises in that same cycle.
- R5: When `wr_req` comes in a cycle with `sys_rst` high, no write is launched. This includes the cycle in which `sys_rst` first rises.
- R6: `wr_busy` stays high for exactly `WR_CYCLES` cycles from the cycle in which `wr_start` is high. A rise of `sys_rst` during that time does not shorten it.
- R7: A `wr_req` in a cycle where `wr_busy` is high is ignored: no `wr_start` follows and the busy period is not extended.
- R8: `xfer_abort` is a one-cycle pulse. It is high after the edge that samples the first high cycle of `sys_rst`, and only if `xfer_active` was high in that cycle.
- R9: After `sys_rst` falls, `xfer_en` stays 0, even with `xfer_active` high, until a new `xfer_start` is seen with `sys_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| sys_rst | input | 1 | Monitored system reset level, active high |
| xfer_start | input | 1 | Strobe from the decoder: a bus transaction begins |
| xfer_active | input | 1 | High while the decoder is inside a transaction |
| wr_req | input | 1 | Strobe from the decoder requesting an internal write |
| xfer_abort | output | 1 | One-cycle abort of the running transaction |
| xfer_en | output | 1 | Transaction path enabled |
| wr_start | output | 1 | One-cycle launch pulse to the write engine |
| wr_busy | output | 1 | Internal write cycle in progress |

## Verification
The bench drives reset high in the middle of a write. A design that tied the write timer to `sys_rst` would let `wr_busy` drop early at that point. It raises a write request in the very cycle reset rises, where a guard with the wrong priority would launch a write. It also requests a second write during a busy period, where a timer that reloads on every request would stretch the cycle.

On the bus side, the bench raises reset both with and without an active transaction, so an abort taken from the level rather than the edge, or one not qualified by activity, shows up as an extra or missing pulse. Finally it keeps `xfer_active` high across the release of reset. A guard that re-enabled on release instead of waiting for a fresh start strobe would show `xfer_en` coming back on its own.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_RUN  = 1'b1
  } wr_state_e;
endpackage

// File: rtl/mrg_edge_abort.sv
module mrg_edge_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic xfer_active,
  output logic xfer_abort
);
  logic lvl_q, lvl_d;
  logic abort_q, abort_d;

  always_comb begin
    lvl_d   = sys_rst;
    abort_d = sys_rst & ~lvl_q & xfer_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      abort_q <= abort_d;
    end
  end

  assign xfer_abort = abort_q;
endmodule

// File: rtl/mrg_xfer_gate.sv
module mrg_xfer_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic xfer_start,
  input  logic xfer_active,
  output logic xfer_en
);
  logic en_q, en_d;

  always_comb begin
    if (sys_rst)         en_d = 1'b0;
    else if (xfer_start) en_d = 1'b1;
    else                 en_d = en_q & xfer_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign xfer_en = en_q;
endmodule

// File: rtl/mrg_write_timer.sv
module mrg_write_timer #(
  parameter int WR_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic wr_start,
  output logic wr_busy
);
  import mrg_pkg::*;

  localparam int CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  wr_state_e        st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             pulse_q, pulse_d;
  logic             cnt_en;

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    pulse_d = 1'b0;
    cnt_en  = 1'b0;
    unique case (st_q)
      WR_IDLE: begin
        if (launch) begin
          st_d    = WR_RUN;
          left_d  = LAST;
          pulse_d = 1'b1;
          cnt_en  = 1'b1;
        end
      end
      WR_RUN: begin
        cnt_en = 1'b1;
        if (left_q == '0) st_d = WR_IDLE;
        else              left_d = left_q - 1'b1;
      end
      default: st_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WR_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (cnt_en) left_q <= left_d;
  end

  assign wr_start = pulse_q;
  assign wr_busy  = (st_q == WR_RUN);
endmodule

// File: rtl/mem_rst_guard.sv
module mem_rst_guard #(
  parameter int WR_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic xfer_start,
  input  logic xfer_active,
  input  logic wr_req,
  output logic xfer_abort,
  output logic xfer_en,
  output logic wr_start,
  output logic wr_busy
);
  logic [1:0] rs_q;
  logic       rst_s_n;
  logic       launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // reset wins over a same-cycle request; a running write refuses new ones
  assign launch = wr_req & ~sys_rst & ~wr_busy;

  mrg_edge_abort u_abort (
    .clk(clk), .rst_n(rst_s_n), .sys_rst(sys_rst),
    .xfer_active(xfer_active), .xfer_abort(xfer_abort)
  );

  mrg_xfer_gate u_gate (
    .clk(clk), .rst_n(rst_s_n), .sys_rst(sys_rst),
    .xfer_start(xfer_start), .xfer_active(xfer_active), .xfer_en(xfer_en)
  );

  mrg_write_timer #(.WR_CYCLES(WR_CYCLES)) u_wr (
    .clk(clk), .rst_n(rst_s_n), .launch(launch),
    .wr_start(wr_start), .wr_busy(wr_busy)
  );
endmodule

// File: rtl/mem_rst_guard_chk.sv
module mem_rst_guard_chk #(
  parameter int WR_CYCLES = 500_000
) (
  input logic clk,
  input logic rst_n,
  input logic sys_rst,
  input logic xfer_start,
  input logic xfer_active,
  input logic wr_req,
  input logic xfer_abort,
  input logic xfer_en,
  input logic wr_start,
  input logic wr_busy
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= 0;
    else if (wr_busy) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  AST_EN_OFF_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !xfer_en); // R3
  AST_NO_START_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !wr_start); // R5
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> wr_busy); // R4
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> run_len == WR_CYCLES); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> !wr_start); // R7
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> !xfer_abort); // R8
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> $past(sys_rst) && $past(xfer_active)); // R8
  AST_EN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en) |-> $past(xfer_start)); // R9
endmodule

bind mem_rst_guard mem_rst_guard_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .xfer_start(xfer_start),
  .xfer_active(xfer_active), .wr_req(wr_req), .xfer_abort(xfer_abort),
  .xfer_en(xfer_en), .wr_start(wr_start), .wr_busy(wr_busy)
);

// File: tb/tb_mem_rst_guard.sv
module tb_mem_rst_guard;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b0, xfer_start = 1'b0, xfer_active = 1'b0, wr_req = 1'b0;
  logic xfer_abort, xfer_en, wr_start, wr_busy;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] exp;   // {abort, en, start, busy}
    string      tag;
  } item_t;
  item_t q[$];

  // reference state
  logic m_prev = 1'b0, m_en = 1'b0, m_busy = 1'b0;
  int   m_left = 0;

  always #5 clk = ~clk;

  mem_rst_guard #(.WR_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .xfer_start(xfer_start),
    .xfer_active(xfer_active), .wr_req(wr_req), .xfer_abort(xfer_abort),
    .xfer_en(xfer_en), .wr_start(wr_start), .wr_busy(wr_busy)
  );

  task automatic step(input logic sr, input logic st, input logic act,
                      input logic wq, input string tag);
    item_t it;
    logic ab, en, go;
    @(negedge clk);
    sys_rst = sr; xfer_start = st; xfer_active = act; wr_req = wq;
    ab = sr && !m_prev && act;
    en = sr ? 1'b0 : (st ? 1'b1 : (m_en && act));
    go = wq && !sr && !m_busy;
    if (go) begin
      m_busy = 1'b1; m_left = N - 1;
    end else if (m_busy) begin
      if (m_left == 0) m_busy = 1'b0;
      else m_left = m_left - 1;
    end
    m_prev = sr; m_en = en;
    it.exp = {ab, en, go, m_busy};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare outputs just after the edge that consumed the inputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it = q.pop_front();
        act = {xfer_abort, xfer_en, wr_start, wr_busy};
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: {abort,en,start,busy} actual %b expected %b",
                   it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state
    step(0,0,0,0,"R1"); step(0,0,0,0,"R1");
    // R2 normal transaction
    step(0,1,1,0,"R2");
    for (int i = 0; i < 3; i++) step(0,0,1,0,"R2");
    step(0,0,0,0,"R2"); step(0,0,0,0,"R2");
    // R4 write launch, R7 request while busy, R6 full length
    step(0,0,0,1,"R4");
    step(0,0,0,0,"R6"); step(0,0,0,0,"R6");
    step(0,0,0,1,"R7");
    for (int i = 0; i < N; i++) step(0,0,0,0,"R6");
    // R8 abort with active transfer, R3 refusal, R5 blocked write
    step(0,1,1,0,"R2"); step(0,0,1,0,"R2");
    step(1,0,1,0,"R8"); step(1,0,1,0,"R8");
    step(1,1,1,0,"R3"); step(1,0,1,1,"R5"); step(1,0,1,0,"R5");
    // R9 no re-enable on release
    step(0,0,1,0,"R9"); step(0,0,1,0,"R9"); step(0,0,1,0,"R9");
    step(0,1,1,0,"R9"); step(0,0,1,0,"R9"); step(0,0,0,0,"R2");
    // R6 reset during a write does not cut it short
    step(0,0,0,1,"R4"); step(0,0,0,0,"R6");
    step(1,0,0,0,"R6"); step(1,0,0,1,"R5");
    for (int i = 0; i < N; i++) step(1,0,0,0,"R6");
    step(0,0,0,0,"R6");
    // R5 request in the very cycle reset rises
    step(1,0,0,1,"R5"); step(0,0,0,0,"R5"); step(0,0,0,0,"R5");
    // R8 reset rise without active transfer gives no abort
    step(1,0,0,0,"R8"); step(1,0,0,0,"R8"); step(0,0,0,0,"R8");
    step(0,0,0,0,"R1");
    @(posedge clk); #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule